// File: doc/BRIEF.md
# Self-Sequencing Serial Flash Cycle Engine

This block runs complete serial-flash operations from three host inputs: a cycle kind, a 25-bit linear flash address and a byte count. Software writes the address, fills the 64-byte data buffer when it programs, and sets the start bit in the control register. The engine then builds every SPI frame by itself. A read needs one frame. A program or erase first sends a write-enable frame, then the command frame, then a series of status-read frames that continue until the device reports it is no longer busy.

Before any frame goes out, the engine checks the request. It rejects an erase whose address is not aligned to the configured erase granule, any read or program that would run past the end of a 256-byte page, and the reserved cycle kind. A rejected request raises the access-error flag and never reaches the pins. Status polling has a limit on the number of polls. When the limit is reached, the engine raises the cycle-error flag.

The sequencer has five states. IDLE waits for a start. CHECK validates the request. LOAD hands one byte to the bit shifter. WAIT holds until that byte has been shifted. GAP raises chip select between frames and picks the next frame.

Its transitions are:
- IDLE→CHECK when a start is written.
- CHECK→IDLE when the request is rejected.
- CHECK→LOAD when the request is accepted.
- LOAD→WAIT always.
- WAIT→LOAD when more bytes remain in the frame.
- WAIT→GAP after the last byte of the frame.
- GAP→LOAD for the next frame, or for another poll.
- GAP→IDLE when the cycle finishes with done or with error.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, and the done, cycle-error, access-error and lock bits are 0. The control register and the address register read 0.
- R2: Register map, by word offset: 0 is control, 1 is status, 2 is address, and 16 to 31 are data words. In control, bit 0 written as 1 starts a cycle. Bits 2:1 are the kind (0 read, 1 reserved, 2 program, 3 erase). Bits 13:8 are the byte count minus one. Control reads back the kind and count, with bit 0 reading 0. Status bit 5 reads 1 while a cycle is in progress.
- R3: A read sends a single frame. The frame is opcode 0x03, then address bits 23:0 as three bytes, most significant first, then count clocked-in bytes. Data byte i is stored at data word i/4, bits 8*(i%4)+7:8*(i%4). The done bit (status bit 0) is then set. The SPI is mode 0: the clock idles low, data goes out MSB first, and data is sampled on the rising clock edge.
- R4: A program sends a frame holding only 0x06. It then sends a frame of 0x02, the three address bytes, and count bytes taken from the data buffer in the R3 byte order.
- R5: An erase sends a 0x06 frame, then a frame of an erase opcode followed by the three address bytes and no data. The erase opcode depends on the granule input: 0 gives 0x81, 1 gives 0x20, 2 gives 0x40, 3 gives 0xD8.
- R6: After the command frame of a program or erase, the engine sends status-read frames. Each is 0x05 followed by one clocked-in byte. Polling continues while bit 0 of that byte is 1. Done is set once bit 0 is 0.
- R7: If POLL_LIMIT polls all return busy, the cycle ends with cycle error (status bit 1) set and done left clear.
- R8: The following requests set access error (status bit 2), produce no frame and leave done clear:
  - an erase whose address is not aligned to the granule (256 B, 4 KiB, 8 KiB or 64 KiB for codes 0 to 3);
  - a read or program where the address low byte plus the count minus one exceeds 255;
  - the reserved kind.

  A transfer that ends exactly on the last byte of a page is accepted.
- R9: Writing 1 to a status bit 0, 1 or 2 clears that bit. Writing 0 leaves it unchanged.
- R10: Status bits 4:3 show the erase-granule input code.
- R11: The address register holds all 32 written bits and reads them back. Only bits 24:0 form the flash address. Bits above bit 23 affect neither the address bytes sent nor the page check.
- R12: Writing 1 to status bit 15 sets the lock bit. The lock bit stays set until reset, including when status is written with bit 15 equal to 0.
- R13: While a cycle is in progress, writes to the control register are ignored. They neither change the value read back nor start a second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| erase_gran | input | 2 | Static erase granule code |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
Each fault in the sequencer shows up at the pins within a frame. A wrong frame choice or a wrong byte index gives a missing write-enable frame, a wrong opcode, or a wrong byte count, and the flash model logs each of these against the expected frame list. A busy flag captured wrongly, or a poll counter that is off by one, changes the number of 0x05 frames, and the bench counts them exactly in both the finite-busy test and the timeout test. A validation fault makes a rejected request drive chip select low, or makes a legal request come back as an access error, and both are visible in the frame log and the status register right after the start.

// File: rtl/hsf_pkg.sv
package hsf_pkg;
    typedef enum logic [1:0] {K_READ = 2'd0, K_RSVD = 2'd1, K_PROG = 2'd2, K_ERASE = 2'd3} kind_t;
    typedef enum logic [1:0] {FR_WREN, FR_MAIN, FR_POLL} frame_t;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_RDSR = 8'h05;

    function automatic logic [7:0] erase_opcode(input logic [1:0] g);
        case (g)
            2'd0:    return 8'h81;
            2'd1:    return 8'h20;
            2'd2:    return 8'h40;
            default: return 8'hD8;
        endcase
    endfunction

    function automatic logic [24:0] gran_mask(input logic [1:0] g);
        case (g)
            2'd0:    return 25'h00000FF;
            2'd1:    return 25'h0000FFF;
            2'd2:    return 25'h0001FFF;
            default: return 25'h000FFFF;
        endcase
    endfunction
endpackage

// File: rtl/hsf_byte_shifter.sv
module hsf_byte_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              spi_miso,
    output logic              spi_sck,
    output logic              spi_mosi,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              active
);
    localparam int BC_W = $clog2(BYTE_W);

    logic              phase_q;
    logic [BC_W-1:0]   bit_q;
    logic [BYTE_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active  <= 1'b0;
            phase_q <= 1'b0;
            bit_q   <= '0;
            sh_q    <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                sh_q    <= tx_byte;
                active  <= 1'b1;
                phase_q <= 1'b0;
                bit_q   <= '0;
            end else if (active) begin
                if (!phase_q) begin
                    phase_q <= 1'b1;
                end else begin
                    phase_q <= 1'b0;
                    sh_q    <= {sh_q[BYTE_W-2:0], spi_miso};
                    bit_q   <= bit_q + 1'b1;
                    if (bit_q == BC_W'(BYTE_W - 1)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end
                end
            end
        end
    end

    assign spi_sck  = active & phase_q;
    assign spi_mosi = sh_q[BYTE_W-1];
    assign rx_byte  = sh_q;

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active); // R3
endmodule

// File: rtl/hsf_sequencer.sv
module hsf_sequencer
    import hsf_pkg::*;
#(
    parameter int DATA_BYTES = 64,
    parameter int POLL_LIMIT = 4096,
    parameter int PAGE_BYTES = 256,
    parameter int FLA_W      = 25
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          go,
    input  kind_t                         go_kind,
    input  logic [FLA_W-1:0]              go_fla,
    input  logic [$clog2(DATA_BYTES)-1:0] go_cnt,
    input  logic [1:0]                    granule,
    input  logic [7:0]                    buf_rd_data,
    output logic [$clog2(DATA_BYTES)-1:0] buf_rd_idx,
    output logic                          buf_wr_en,
    output logic [7:0]                    buf_wr_data,
    output logic                          busy,
    output logic                          evt_done,
    output logic                          evt_err,
    output logic                          evt_ael,
    output logic                          cs_n,
    output logic                          sh_start,
    output logic [7:0]                    sh_tx,
    input  logic                          sh_done,
    input  logic [7:0]                    sh_rx
);
    localparam int CNT_W  = $clog2(DATA_BYTES);
    localparam int IDX_W  = $clog2(DATA_BYTES + 5);
    localparam int PW     = $clog2(POLL_LIMIT + 1);
    localparam int PAGE_W = $clog2(PAGE_BYTES);

    typedef enum logic [2:0] {S_IDLE, S_CHECK, S_LOAD, S_WAIT, S_GAP} state_t;

    state_t             state_q, state_n;
    frame_t             frame_q, frame_n;
    logic [IDX_W-1:0]   idx_q, idx_n, last_idx;
    logic [PW-1:0]      poll_q, poll_n;
    kind_t              kind_q;
    logic [FLA_W-1:0]   fla_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [1:0]         gran_q;
    logic               busy_bit_q, bad, crosses;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            frame_q    <= FR_WREN;
            idx_q      <= '0;
            poll_q     <= '0;
            kind_q     <= K_READ;
            fla_q      <= '0;
            cnt_q      <= '0;
            gran_q     <= '0;
            busy_bit_q <= 1'b0;
        end else begin
            state_q <= state_n;
            frame_q <= frame_n;
            idx_q   <= idx_n;
            poll_q  <= poll_n;
            if (state_q == S_IDLE && go) begin
                kind_q <= go_kind;
                fla_q  <= go_fla;
                cnt_q  <= go_cnt;
                gran_q <= granule;
            end
            if (state_q == S_WAIT && sh_done && frame_q == FR_POLL && idx_q == IDX_W'(1))
                busy_bit_q <= sh_rx[0];
        end
    end

    assign crosses = ({1'b0, fla_q[PAGE_W-1:0]} + (PAGE_W+1)'(cnt_q)) > (PAGE_W+1)'(PAGE_BYTES - 1);
    assign bad = (kind_q == K_RSVD)
               || (kind_q == K_ERASE && (fla_q & gran_mask(gran_q)) != '0)
               || (kind_q != K_ERASE && crosses);

    always_comb begin
        case (frame_q)
            FR_WREN: last_idx = '0;
            FR_POLL: last_idx = IDX_W'(1);
            default: last_idx = (kind_q == K_ERASE) ? IDX_W'(3) : IDX_W'(cnt_q) + IDX_W'(4);
        endcase
    end

    assign buf_rd_idx  = CNT_W'(idx_q - IDX_W'(4));
    assign buf_wr_data = sh_rx;

    always_comb begin
        sh_tx = 8'h00;
        case (frame_q)
            FR_WREN: sh_tx = OP_WREN;
            FR_POLL: sh_tx = (idx_q == '0) ? OP_RDSR : 8'h00;
            default: begin
                case (idx_q)
                    IDX_W'(0): sh_tx = (kind_q == K_READ) ? OP_READ :
                                       (kind_q == K_PROG) ? OP_PROG : erase_opcode(gran_q);
                    IDX_W'(1): sh_tx = fla_q[23:16];
                    IDX_W'(2): sh_tx = fla_q[15:8];
                    IDX_W'(3): sh_tx = fla_q[7:0];
                    default:   sh_tx = (kind_q == K_PROG) ? buf_rd_data : 8'h00;
                endcase
            end
        endcase
    end

    always_comb begin
        state_n   = state_q;
        frame_n   = frame_q;
        idx_n     = idx_q;
        poll_n    = poll_q;
        sh_start  = 1'b0;
        buf_wr_en = 1'b0;
        evt_done  = 1'b0;
        evt_err   = 1'b0;
        evt_ael   = 1'b0;
        unique case (state_q)
            S_IDLE: if (go) state_n = S_CHECK;
            S_CHECK: begin
                if (bad) begin
                    evt_ael = 1'b1;
                    state_n = S_IDLE;
                end else begin
                    frame_n = (kind_q == K_READ) ? FR_MAIN : FR_WREN;
                    idx_n   = '0;
                    state_n = S_LOAD;
                end
            end
            S_LOAD: begin
                sh_start = 1'b1;
                state_n  = S_WAIT;
            end
            S_WAIT: begin
                if (sh_done) begin
                    buf_wr_en = (frame_q == FR_MAIN) && (kind_q == K_READ) && (idx_q >= IDX_W'(4));
                    if (idx_q == last_idx) begin
                        state_n = S_GAP;
                    end else begin
                        idx_n   = idx_q + 1'b1;
                        state_n = S_LOAD;
                    end
                end
            end
            S_GAP: begin
                idx_n = '0;
                case (frame_q)
                    FR_WREN: begin
                        frame_n = FR_MAIN;
                        state_n = S_LOAD;
                    end
                    FR_MAIN: begin
                        if (kind_q == K_READ) begin
                            evt_done = 1'b1;
                            state_n  = S_IDLE;
                        end else begin
                            frame_n = FR_POLL;
                            poll_n  = '0;
                            state_n = S_LOAD;
                        end
                    end
                    default: begin
                        if (!busy_bit_q) begin
                            evt_done = 1'b1;
                            state_n  = S_IDLE;
                        end else if (poll_q == PW'(POLL_LIMIT - 1)) begin
                            evt_err = 1'b1;
                            state_n = S_IDLE;
                        end else begin
                            poll_n  = poll_q + 1'b1;
                            state_n = S_LOAD;
                        end
                    end
                endcase
            end
            default: state_n = S_IDLE;
        endcase
    end

    assign busy = (state_q != S_IDLE);
    assign cs_n = !(state_q == S_LOAD || state_q == S_WAIT);

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_done && evt_err)); // R7
    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_q == FR_POLL && busy) |-> poll_q < PW'(POLL_LIMIT)); // R7
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
    import hsf_pkg::*;
#(
    parameter int DATA_BYTES = 64,
    parameter int POLL_LIMIT = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [4:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [1:0]  erase_gran,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int CNT_W  = $clog2(DATA_BYTES);
    localparam int WORD_W = CNT_W - 2;
    localparam int REG_AW = WORD_W + 1;
    localparam logic [REG_AW-1:0] RA_CTRL = REG_AW'(0);
    localparam logic [REG_AW-1:0] RA_STAT = REG_AW'(1);
    localparam logic [REG_AW-1:0] RA_ADDR = REG_AW'(2);

    kind_t             kind_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [31:0]       addr_q;
    logic              st_done, st_err, st_ael, lock_q;
    logic [7:0]        dbuf [DATA_BYTES];

    logic              seq_busy, go, stat_we, data_we;
    logic              evt_done, evt_err, evt_ael;
    logic [CNT_W-1:0]  buf_rd_idx;
    logic              buf_wr_en;
    logic [7:0]        buf_wr_data;
    logic              sh_start, sh_done, sh_active;
    logic [7:0]        sh_tx, sh_rx;
    logic [WORD_W-1:0] word_sel;

    assign word_sel = reg_addr[WORD_W-1:0];
    assign data_we  = reg_we && reg_addr[REG_AW-1];
    assign stat_we  = reg_we && reg_addr == RA_STAT;
    assign go       = reg_we && reg_addr == RA_CTRL && reg_wdata[0] && !seq_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= K_READ;
            cnt_q   <= '0;
            addr_q  <= '0;
            st_done <= 1'b0;
            st_err  <= 1'b0;
            st_ael  <= 1'b0;
            lock_q  <= 1'b0;
        end else begin
            if (reg_we && reg_addr == RA_CTRL && !seq_busy) begin
                kind_q <= kind_t'(reg_wdata[2:1]);
                cnt_q  <= reg_wdata[8 +: CNT_W];
            end
            if (reg_we && reg_addr == RA_ADDR) addr_q <= reg_wdata;
            st_done <= evt_done | (st_done & ~(stat_we & reg_wdata[0]));
            st_err  <= evt_err  | (st_err  & ~(stat_we & reg_wdata[1]));
            st_ael  <= evt_ael  | (st_ael  & ~(stat_we & reg_wdata[2]));
            lock_q  <= lock_q | (stat_we & reg_wdata[15]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < DATA_BYTES; b++) dbuf[b] <= '0;
        end else begin
            for (int b = 0; b < DATA_BYTES; b++) begin
                if (buf_wr_en && buf_rd_idx == CNT_W'(b))
                    dbuf[b] <= buf_wr_data;
                else if (data_we && word_sel == WORD_W'(b / 4))
                    dbuf[b] <= reg_wdata[(b % 4) * 8 +: 8];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[REG_AW-1]) begin
            for (int k = 0; k < 4; k++) reg_rdata[k*8 +: 8] = dbuf[{word_sel, 2'(k)}];
        end else if (reg_addr == RA_CTRL) begin
            reg_rdata[8 +: CNT_W] = cnt_q;
            reg_rdata[2:1]        = kind_q;
        end else if (reg_addr == RA_STAT) begin
            reg_rdata[15]  = lock_q;
            reg_rdata[5]   = seq_busy;
            reg_rdata[4:3] = erase_gran;
            reg_rdata[2:0] = {st_ael, st_err, st_done};
        end else if (reg_addr == RA_ADDR) begin
            reg_rdata = addr_q;
        end
    end

    hsf_sequencer #(.DATA_BYTES(DATA_BYTES), .POLL_LIMIT(POLL_LIMIT)) seq_i (
        .clk(clk), .rst_n(rst_n), .go(go), .go_kind(kind_t'(reg_wdata[2:1])),
        .go_fla(addr_q[24:0]), .go_cnt(reg_wdata[8 +: CNT_W]), .granule(erase_gran),
        .buf_rd_data(dbuf[buf_rd_idx]), .buf_rd_idx(buf_rd_idx), .buf_wr_en(buf_wr_en),
        .buf_wr_data(buf_wr_data), .busy(seq_busy), .evt_done(evt_done), .evt_err(evt_err),
        .evt_ael(evt_ael), .cs_n(spi_cs_n), .sh_start(sh_start), .sh_tx(sh_tx),
        .sh_done(sh_done), .sh_rx(sh_rx)
    );

    hsf_byte_shifter #(.BYTE_W(8)) shf_i (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(sh_tx), .spi_miso(spi_miso),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .done(sh_done), .rx_byte(sh_rx),
        .active(sh_active)
    );

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q); // R12
    AST_IDLE_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_busy |-> (spi_cs_n && !spi_sck && !sh_active)); // R1
    AST_AEL_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_ael) |-> ($past(spi_cs_n) && spi_cs_n)); // R8
    AST_SCK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> !spi_cs_n); // R3
endmodule

// File: tb/flash_seq_ctrl_tb_top.sv
module flash_seq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  erase_gran = 2'd0;
    logic        spi_sck, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_seq_ctrl #(.DATA_BYTES(64), .POLL_LIMIT(LIMIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .erase_gran(erase_gran),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // ---------------- flash device model ----------------
    logic [7:0] in_sh = '0;
    logic [7:0] out_sh = '0;
    int bitc = 0, bytec = 0, fcount = 0, mlen = 0, busy_left = 0;
    logic [7:0] cb [0:79];
    logic [7:0] mb [0:79];
    logic [7:0] fop [0:127];
    int flen [0:127];

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7 + 17) % 256);
    endfunction

    always @(negedge spi_cs_n) begin
        bitc = 0;
        bytec = 0;
        out_sh = 8'h00;
    end

    always @(posedge spi_sck) if (!spi_cs_n) begin
        in_sh = {in_sh[6:0], spi_mosi};
        bitc++;
        if (bitc == 8) begin
            bitc = 0;
            if (bytec < 80) cb[bytec] = in_sh;
            bytec++;
            out_sh = 8'h00;
            if (cb[0] == 8'h03 && bytec >= 4) out_sh = pat(bytec - 4);
            else if (cb[0] == 8'h05 && bytec == 1) begin
                out_sh = (busy_left > 0) ? 8'h01 : 8'h00;
                if (busy_left > 0) busy_left--;
            end
        end
    end

    always @(negedge spi_sck) if (!spi_cs_n) begin
        spi_miso = out_sh[7];
        out_sh = {out_sh[6:0], 1'b0};
    end

    always @(posedge spi_cs_n) if (bytec > 0) begin
        if (fcount < 128) begin
            fop[fcount] = cb[0];
            flen[fcount] = bytec;
        end
        fcount++;
        if (cb[0] == 8'h02 || cb[0] == 8'h03) begin
            for (int i = 0; i < 80; i++) mb[i] = cb[i];
            mlen = bytec;
        end
        bytec = 0;
    end

    // ---------------- host helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int n = 0; n < 20000; n++) begin
            rd(5'd1, s);
            if (!s[5]) return;
        end
    endtask

    task automatic run(input logic [31:0] addr, input logic [31:0] ctrl);
        wr(5'd1, 32'h7);
        wr(5'd2, addr);
        wr(5'd0, ctrl);
        wait_idle();
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [31:0] v;
        chk("R1 cs_n idle", 32'(spi_cs_n), 32'd1);
        chk("R1 sck idle", 32'(spi_sck), 32'd0);
        rd(5'd1, v); chk("R1 status", v, 32'h0);
        rd(5'd0, v); chk("R1 ctrl", v, 32'h0);
        rd(5'd2, v); chk("R1 addr", v, 32'h0);
    endtask

    task automatic t_read();
        logic [31:0] v;
        int f0 = fcount;
        wr(5'd1, 32'h7);
        wr(5'd2, 32'h0000_1230);
        wr(5'd0, 32'h0000_0F01);
        rd(5'd1, v); chk("R2 busy bit", 32'(v[5]), 32'd1);
        rd(5'd0, v); chk("R2 ctrl readback", v, 32'h0000_0F00);
        wait_idle();
        chk("R3 frame count", 32'(fcount - f0), 32'd1);
        chk("R3 opcode", 32'(fop[f0]), 32'h03);
        chk("R3 addr bytes", {8'h0, mb[1], mb[2], mb[3]}, 32'h0000_1230);
        chk("R3 frame length", 32'(mlen), 32'd20);
        for (int w = 0; w < 4; w++) begin
            rd(5'(16 + w), v);
            chk("R3 data word", v, {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)});
        end
        rd(5'd1, v); chk("R3 done set", v[2:0], 32'h1);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(5'd1, 32'h0);
        rd(5'd1, v); chk("R9 write 0 keeps done", 32'(v[0]), 32'd1);
        wr(5'd1, 32'h1);
        rd(5'd1, v); chk("R9 write 1 clears done", 32'(v[0]), 32'd0);
    endtask

    task automatic t_write();
        logic [31:0] v;
        int f0;
        wr(5'd16, 32'h4433_2211);
        wr(5'd17, 32'h8877_6655);
        busy_left = 2;
        f0 = fcount;
        run(32'h0000_0040, 32'h0000_0705);
        chk("R4 frames", 32'(fcount - f0), 32'd5);
        chk("R4 wren first", {fop[f0], 8'(flen[f0])}, {8'h06, 8'd1});
        chk("R4 program opcode", 32'(fop[f0+1]), 32'h02);
        chk("R4 program length", 32'(mlen), 32'd12);
        chk("R4 program addr", {8'h0, mb[1], mb[2], mb[3]}, 32'h0000_0040);
        chk("R4 program data lo", {mb[7], mb[6], mb[5], mb[4]}, 32'h4433_2211);
        chk("R4 program data hi", {mb[11], mb[10], mb[9], mb[8]}, 32'h8877_6655);
        chk("R6 poll frames", {fop[f0+2], fop[f0+3], fop[f0+4], 8'(flen[f0+4])}, 32'h0505_0502);
        rd(5'd1, v); chk("R6 done after not busy", v[2:0], 32'h1);
    endtask

    task automatic t_erase();
        logic [31:0] v;
        int f0 = fcount;
        erase_gran = 2'd1;
        busy_left = 0;
        run(32'h0000_2000, 32'h0000_0007);
        chk("R5 erase frames", 32'(fcount - f0), 32'd3);
        chk("R5 4K opcode and len", {fop[f0], fop[f0+1], 8'(flen[f0+1]), fop[f0+2]}, 32'h0620_0405);
        rd(5'd1, v); chk("R5 erase done", v[2:0], 32'h1);
        chk("R10 granule bits", 32'(v[4:3]), 32'd1);
        erase_gran = 2'd3;
        f0 = fcount;
        run(32'h0003_0000, 32'h0000_0007);
        chk("R5 64K opcode", {fop[f0], fop[f0+1], 8'(flen[f0+1])}, 32'h0006_D804);
        erase_gran = 2'd2;
        rd(5'd1, v); chk("R10 granule bits 2", 32'(v[4:3]), 32'd2);
    endtask

    task automatic t_access_err();
        logic [31:0] v;
        int f0 = fcount;
        erase_gran = 2'd1;
        run(32'h0000_2100, 32'h0000_0007);
        rd(5'd1, v); chk("R8 misaligned erase", v[2:0], 32'h4);
        run(32'h0000_00F8, 32'h0000_0F01);
        rd(5'd1, v); chk("R8 page crossing", v[2:0], 32'h4);
        run(32'h0000_0000, 32'h0000_0003);
        rd(5'd1, v); chk("R8 reserved kind", v[2:0], 32'h4);
        chk("R8 no frames sent", 32'(fcount - f0), 32'd0);
        run(32'h0000_00F0, 32'h0000_0F01);
        rd(5'd1, v); chk("R8 page end accepted", v[2:0], 32'h1);
        wr(5'd1, 32'h4);
        rd(5'd1, v); chk("R9 clear ael only", v[2:0], 32'h1);
    endtask

    task automatic t_timeout();
        logic [31:0] v;
        int f0 = fcount;
        busy_left = 100;
        run(32'h0000_0000, 32'h0000_0005);
        chk("R7 poll count at limit", 32'(fcount - f0), 32'(2 + LIMIT));
        rd(5'd1, v); chk("R7 cycle error", v[2:0], 32'h2);
        wr(5'd1, 32'h2);
        rd(5'd1, v); chk("R9 clear error", v[2:0], 32'h0);
        busy_left = 0;
    endtask

    task automatic t_ctrl_busy();
        logic [31:0] v;
        int f0 = fcount;
        wr(5'd1, 32'h7);
        wr(5'd2, 32'h0000_0000);
        wr(5'd0, 32'h0000_0201);
        wr(5'd0, 32'h0000_0507);
        rd(5'd0, v); chk("R13 ctrl held while busy", v, 32'h0000_0200);
        wait_idle();
        repeat (50) @(negedge clk);
        chk("R13 no second cycle", 32'(fcount - f0), 32'd1);
        rd(5'd1, v); chk("R13 status", {26'h0, v[5], v[2:0]}, 32'h1);
    endtask

    task automatic t_upper_addr();
        logic [31:0] v;
        run(32'hFE00_0100, 32'h0000_0201);
        rd(5'd2, v); chk("R11 addr readback", v, 32'hFE00_0100);
        chk("R11 addr bytes", {8'h0, mb[1], mb[2], mb[3]}, 32'h0000_0100);
        rd(5'd1, v); chk("R11 accepted", v[2:0], 32'h1);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        wr(5'd1, 32'h8000);
        rd(5'd1, v); chk("R12 lock set", 32'(v[15]), 32'd1);
        wr(5'd1, 32'h0000_0007);
        rd(5'd1, v); chk("R12 lock sticky", 32'(v[15]), 32'd1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read();
        t_w1c();
        t_write();
        t_erase();
        t_access_err();
        t_timeout();
        t_ctrl_busy();
        t_upper_addr();
        t_lock();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule